// File: doc/BRIEF.md
# Multi-Channel Interval Timer Bank

This peripheral holds a bank of independent up-counting timer channels behind a small synchronous register bus. Each channel owns four word registers: a control word, a tick configuration word, a live counter and a compare value. Two shared words hold the interrupt mask and the pending flags. Software acknowledges an interrupt by writing ones to the pending word. A single level interrupt output combines all channels.

A channel runs in one of three ways. In one-shot mode it counts up to the compare value, flags an interrupt and stops itself. In repeat mode it flags an interrupt, restarts from zero and keeps going, which gives a periodic tick. In free-run mode it never flags an interrupt and serves as a monotonic time base. Each channel takes its count pulses either from every core clock or from an external slow strobe, and may halve that rate.

The bus read path is combinational from the address. A write takes effect at the clock edge where `we` is high.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: Channel n (1..NCH) decodes control at 0x10*n, tick configuration at 0x10*n+0x04, counter at 0x10*n+0x08 and compare at 0x10*n+0x0C. The interrupt mask sits at 0x00 and the pending/acknowledge word at 0x08, with channel n on bit n-1 of both. Any other address reads 0.
- R3: In the control word, bit 0 is run-enable, bit 1 is a counter-clear strobe that always reads back 0, and bits [5:4] select the mode: 0 one-shot, 1 repeat, 2 or 3 free-run. Enable and mode read back as written.
- R4: An enabled channel adds 1 to its counter on each count pulse. A disabled channel holds its counter. A write to the counter address loads the written value.
- R5: A control write with bit 1 set zeroes the counter and the halving phase. A control write with bit 1 clear leaves the counter value unchanged.
- R6: In the tick configuration word, bit 4 = 0 takes one pulse per clock and bit 4 = 1 takes one pulse per cycle with `slow_tick` high. Bit 0 = 1 passes only every second such pulse, starting with the second pulse after a clear.
- R7: In one-shot mode, the count pulse that brings the counter to the compare value sets the pending bit. The counter then holds the compare value and the enable bit drops to 0.
- R8: In repeat mode, the count pulse that would bring the counter to the compare value sets the pending bit and reloads the counter to 0. The channel stays enabled.
- R9: In free-run mode the pending bit is never set, even when the counter equals the compare value. The counter wraps from 0xFFFFFFFF to 0.
- R10: Writing to 0x08 clears each pending bit whose written bit is 1 and leaves the bits written as 0 unchanged. Writing 0x3F clears all six channels.
- R11: `irq` is high exactly when some channel has both its pending bit and its mask bit set.
- R12: A control write in the same cycle as a count pulse takes priority, and no count happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle strobe from the slow time base |
| we | input | 1 | Write enable for the register bus |
| addr | input | AW | Byte address of the register |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr`, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench drives the compare hit in both stopping modes. A design that reloads instead of holding in one-shot mode, or keeps a one-shot channel running, shows the wrong counter or control value right after the hit. It places a control write on the same edge as a count pulse, and a design without write priority shows a counter of 1 instead of 0. It sets the counter equal to the compare value in free-run mode, where a stray pending bit or a missing wrap shows up in the next reads. The halving prescaler is checked cycle by cycle, because an off-by-one phase moves every later count by one. The bench also writes zeros to the acknowledge word to catch a design that treats it as a plain register.

// File: rtl/tick_timer_bank.sv
module tick_timer_bank #(
  parameter int NCH = 6,
  parameter int DW  = 32,
  parameter int AW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow_tick,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int CHW = AW - 4;
  localparam logic [AW-1:0] MASK_ADDR = '0;
  localparam logic [AW-1:0] PEND_ADDR = AW'(8);

  logic [NCH-1:0]         en_q, src_q, half_q, phase_q, pend_q, mask_q;
  logic [NCH-1:0][1:0]    mode_q;
  logic [NCH-1:0][DW-1:0] cnt_q, cmp_q, cnt_inc;
  logic [NCH-1:0]         sel, ctrl_wr, cfg_wr, cnt_wr, cmp_wr, pulse, tick, hit;

  wire mask_wr = we && addr == MASK_ADDR;
  wire ack_wr  = we && addr == PEND_ADDR;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      sel[i]     = addr[AW-1:4] == CHW'(i + 1) && addr[1:0] == 2'b00;
      ctrl_wr[i] = we && sel[i] && addr[3:2] == 2'd0;
      cfg_wr[i]  = we && sel[i] && addr[3:2] == 2'd1;
      cnt_wr[i]  = we && sel[i] && addr[3:2] == 2'd2;
      cmp_wr[i]  = we && sel[i] && addr[3:2] == 2'd3;
      pulse[i]   = en_q[i] && (src_q[i] ? slow_tick : 1'b1);
      tick[i]    = pulse[i] && (!half_q[i] || phase_q[i]);
      cnt_inc[i] = cnt_q[i] + DW'(1);
      hit[i]     = tick[i] && !mode_q[i][1] && cnt_inc[i] == cmp_q[i]
                   && !ctrl_wr[i] && !cnt_wr[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      src_q   <= '0;
      half_q  <= '0;
      phase_q <= '0;
      pend_q  <= '0;
      mask_q  <= '0;
      mode_q  <= '0;
      cnt_q   <= '0;
      cmp_q   <= '0;
    end else begin
      if (mask_wr) mask_q <= wdata[NCH-1:0];
      pend_q <= (pend_q & ~(ack_wr ? wdata[NCH-1:0] : '0)) | hit;
      for (int i = 0; i < NCH; i++) begin
        if (cfg_wr[i]) begin
          src_q[i]  <= wdata[4];
          half_q[i] <= wdata[0];
        end
        if (cmp_wr[i]) cmp_q[i] <= wdata;
        if (ctrl_wr[i]) begin
          en_q[i]   <= wdata[0];
          mode_q[i] <= wdata[5:4];
          if (wdata[1]) begin
            cnt_q[i]   <= '0;
            phase_q[i] <= 1'b0;
          end
        end else if (cnt_wr[i]) begin
          cnt_q[i] <= wdata;
        end else if (pulse[i]) begin
          phase_q[i] <= half_q[i] & ~phase_q[i];
          if (tick[i]) begin
            if (hit[i] && mode_q[i] == 2'd1) cnt_q[i] <= '0;
            else                             cnt_q[i] <= cnt_inc[i];
            if (hit[i] && mode_q[i] == 2'd0) en_q[i] <= 1'b0;
          end
        end
      end
    end
  end

  assign irq = |(pend_q & mask_q);

  always_comb begin
    rdata = '0;
    if (addr == MASK_ADDR) rdata[NCH-1:0] = mask_q;
    else if (addr == PEND_ADDR) rdata[NCH-1:0] = pend_q;
    for (int i = 0; i < NCH; i++) begin
      if (sel[i]) begin
        case (addr[3:2])
          2'd0: begin
            rdata[0]   = en_q[i];
            rdata[5:4] = mode_q[i];
          end
          2'd1: begin
            rdata[4] = src_q[i];
            rdata[0] = half_q[i];
          end
          2'd2: rdata = cnt_q[i];
          default: rdata = cmp_q[i];
        endcase
      end
    end
  end
endmodule

// File: rtl/tick_timer_bank_chk.sv
module tick_timer_bank_chk #(
  parameter int NCH = 6,
  parameter int DW  = 32,
  parameter int AW  = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   we,
  input logic [AW-1:0]          addr,
  input logic [DW-1:0]          wdata,
  input logic [NCH-1:0]         en,
  input logic [NCH-1:0][1:0]    mode,
  input logic [NCH-1:0][DW-1:0] cnt,
  input logic [NCH-1:0]         pend
);
  localparam int CHW = AW - 4;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    a_r7_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[i]) && mode[i] == 2'd0 |-> !en[i]);

    a_r8_repeat_reload: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[i]) && mode[i] == 2'd1 |-> cnt[i] == '0 && en[i]);

    a_r9_freerun_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[i]) |-> !mode[i][1]);

    a_r4_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !en[i] && !(we && addr[AW-1:4] == CHW'(i + 1)) |=> $stable(cnt[i]));

    a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      we && addr == AW'(8) && wdata[i] && !en[i] |=> !pend[i]);
  end
endmodule

bind tick_timer_bank tick_timer_bank_chk #(.NCH(NCH), .DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
  .en(en_q), .mode(mode_q), .cnt(cnt_q), .pend(pend_q)
);

// File: tb/tick_timer_bank_tb_top.sv
`timescale 1ns/100ps
module tick_timer_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    bit          is_irq;
    logic [7:0]  a;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  tick_timer_bank dut_i (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic chk(input logic [7:0] a, input logic [31:0] e, input string t);
    item_t it;
    @(negedge clk);
    addr = a;
    it.is_irq = 0; it.a = a; it.exp = e; it.tag = t;
    q.push_back(it);
  endtask

  task automatic chk_irq(input logic e, input string t);
    item_t it;
    @(negedge clk);
    it.is_irq = 1; it.a = addr; it.exp = {31'b0, e}; it.tag = t;
    q.push_back(it);
  endtask

  task automatic stk(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); slow_tick = 1'b1;
      @(negedge clk); slow_tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : monitor
    item_t it;
    logic [31:0] act;
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        act = it.is_irq ? {31'b0, irq} : rdata;
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s addr=0x%02h actual=0x%08h expected=0x%08h",
                   it.tag, it.a, act, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : driver
    idle(4);
    rst_n = 1'b1;

    chk(8'h10, 0, "R1 ctrl");
    chk(8'h18, 0, "R1 counter");
    chk(8'h00, 0, "R1 mask");
    chk(8'h08, 0, "R1 pending");
    chk_irq(0, "R1 irq");

    wr(8'h14, 32'h10);
    wr(8'h1C, 5);
    wr(8'h10, 32'h13);
    chk(8'h14, 32'h10, "R2 cfg readback");
    chk(8'h1C, 5, "R2 compare readback");
    chk(8'h10, 32'h11, "R3 clear reads 0");
    stk(2);
    chk(8'h18, 2, "R4 counts");
    idle(3);
    chk(8'h18, 2, "R6 slow source ignores clock");
    stk(2);
    chk(8'h18, 4, "R4 counts");
    chk(8'h08, 0, "R8 no pend before match");
    stk(1);
    chk(8'h18, 0, "R8 reload");
    chk(8'h08, 1, "R8 pend");
    chk(8'h10, 32'h11, "R8 stays enabled");
    chk_irq(0, "R11 masked");
    wr(8'h00, 1);
    chk_irq(1, "R11 unmasked");
    wr(8'h08, 0);
    chk(8'h08, 1, "R10 zero no effect");
    wr(8'h08, 1);
    chk(8'h08, 0, "R10 ack");
    chk_irq(0, "R11 after ack");
    wr(8'h10, 32'h10);
    chk(8'h10, 32'h10, "R3 mode readback");

    wr(8'h24, 32'h11);
    wr(8'h2C, 100);
    wr(8'h20, 32'h03);
    stk(3);
    chk(8'h28, 1, "R6 slow div2");
    stk(1);
    chk(8'h28, 2, "R6 slow div2");

    wr(8'h34, 32'h10);
    wr(8'h3C, 2);
    wr(8'h30, 32'h03);
    stk(2);
    chk(8'h38, 2, "R7 holds compare");
    chk(8'h08, 4, "R7 pend");
    chk(8'h30, 0, "R7 enable cleared");
    stk(1);
    chk(8'h38, 2, "R4 hold disabled");
    chk_irq(0, "R11 other mask");
    wr(8'h00, 4);
    chk_irq(1, "R11");
    wr(8'h08, 32'h3F);
    chk(8'h08, 0, "R10 ack all");
    chk_irq(0, "R11 after ack all");

    wr(8'h30, 32'h01);
    chk(8'h38, 2, "R5 no clear keeps counter");
    stk(1);
    chk(8'h38, 3, "R4 continues");
    wr(8'h30, 32'h02);
    chk(8'h38, 0, "R5 clear");
    chk(8'h30, 0, "R3 clear self-clears");

    wr(8'h30, 32'h01);
    chk(8'h38, 0, "R12 setup");
    @(negedge clk);
    slow_tick = 1'b1; we = 1'b1; addr = 8'h30; wdata = 32'h01;
    @(negedge clk);
    slow_tick = 1'b0; we = 1'b0;
    chk(8'h38, 0, "R12 write wins");
    stk(1);
    chk(8'h38, 1, "R12 counts after");
    wr(8'h30, 0);

    wr(8'h44, 32'h10);
    wr(8'h4C, 32'hFFFF_FFFF);
    wr(8'h48, 32'hFFFF_FFFE);
    chk(8'h48, 32'hFFFF_FFFE, "R4 counter load");
    wr(8'h40, 32'h31);
    chk(8'h40, 32'h31, "R3 freerun readback");
    stk(1);
    chk(8'h48, 32'hFFFF_FFFF, "R9 reaches compare");
    chk(8'h08, 0, "R9 no pend");
    stk(1);
    chk(8'h48, 0, "R9 wrap");
    chk(8'h08, 0, "R9 no pend after wrap");

    wr(8'h54, 0);
    wr(8'h50, 32'h33);
    chk(8'h58, 1, "R6 fast div1");
    chk(8'h58, 2, "R6 fast div1");
    wr(8'h64, 1);
    wr(8'h60, 32'h33);
    chk(8'h68, 0, "R6 fast div2");
    chk(8'h68, 1, "R6 fast div2");
    chk(8'h68, 1, "R6 fast div2");
    chk(8'h68, 2, "R6 fast div2");

    chk(8'h74, 0, "R2 unmapped channel");
    chk(8'h04, 0, "R2 hole");

    idle(3);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule